// File: doc/BRIEF.md
# Flash Rewrite Enable Guard

This block decides whether the CPU may reprogram the on-chip flash. It watches every CPU bus write and keeps a small mode register whose two guarded bits, the rewrite enable and the lock release, can only be turned on by a strict two-step handshake. The CPU first writes the bit as 0 and then, on its very next bus write, writes it as 1. Both writes must be byte-wide, with no interrupt acknowledge or DMA activity between them, and the NMI pin must stay high.

Turning rewrite off has its own rule: the flash must be in read-array mode, and the write must be word-wide with a zero upper byte. An NMI falling edge or a watchdog event returns the guard and a companion auxiliary mode byte to their reset values. When rewrite was enabled at that moment, the block also emits a one-cycle abort pulse. A sticky error flag reports two cases: an enable attempt made while the wait-state bit or the clock check is not satisfied, and an odd-address write into user ROM during rewrite.

Top module: `flash_rewrite_guard`

## Requirements
- R1: After reset, rw_en, lk_rel, abort_p, seq_err are 0 and aux_q is 8'h00.
- R2: A byte write (bus_word=0) to the control address 16'h0057 with bit 1 clear, followed by the very next bus write being a byte write there with bit 1 set, with nmi_level high during both, wait_set=1 and clk_ok=1, sets rw_en in the cycle after the second write and clears seq_err.
- R3: A word write (bus_word=1) to the control address neither arms nor completes the sequence.
- R4: The armed state is cancelled by any other bus write, or by any cycle with irq_ack or dma_busy high; a cycle with no write and no such event keeps it.
- R5: If nmi_level is low during either write of the sequence, the bit is not set.
- R6: A completing write made while wait_set=0 or clk_ok=0 leaves rw_en at 0 and sets seq_err, which stays set until reset or a successful enable.
- R7: rw_en falls to 0 only through a word write to the control address with bits 15:8 equal to 8'h00 and bit 1 clear, while read_array=1. Byte writes and word writes failing any of these conditions leave it at 1.
- R8: A falling edge on nmi_level, or wdt_evt high, clears rw_en, lk_rel and aux_q, and cancels arming in the next cycle. abort_p is then high for exactly one cycle if rw_en was 1. A forced reset wins over a completing write in the same cycle.
- R9: While rw_en=1, a write at or above address 16'h8000 with address bit 0 set sets seq_err. Even addresses do not, and neither do odd ones while rw_en=0.
- R10: A write to address 16'h0055 loads bus_wdata[7:0] into aux_q.
- R11: lk_rel (bit 2) is set by the same two-step sequence, without the wait-state and clock conditions. A byte write to the control address with bit 2 clear drops it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | CPU bus write strobe, one cycle per write |
| bus_word | input | 1 | 1 = word-wide write, 0 = byte-wide |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 16 | Write data |
| irq_ack | input | 1 | Interrupt acknowledge cycle |
| dma_busy | input | 1 | DMA transfer cycle |
| nmi_level | input | 1 | NMI pin level, active low |
| wdt_evt | input | 1 | Watchdog interrupt event |
| read_array | input | 1 | Flash is in read-array mode |
| wait_set | input | 1 | Internal-memory wait state enabled |
| clk_ok | input | 1 | CPU clock within the rewrite limit |
| rw_en | output | 1 | Rewrite enable |
| lk_rel | output | 1 | Lock release |
| aux_q | output | 8 | Auxiliary mode byte |
| abort_p | output | 1 | One-cycle rewrite abort pulse |
| seq_err | output | 1 | Sticky sequence error |

## Verification
The forced reset can land in the same cycle as the completing 1-write of an enable sequence. To provoke this, the bench raises wdt_evt during that write with every other condition valid. It then requires rw_en and seq_err to stay 0 and abort_p to stay low, because rewrite was not yet on. The sequence itself is swept over every combination of the write sizes, the NMI levels, the wait and clock conditions, and five kinds of gap between the writes. The expected enable and error flags are computed from those inputs.

// File: rtl/flash_rewrite_guard.sv
module flash_rewrite_guard #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h0057,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 'h0055,
  parameter logic [ADDR_W-1:0] ROM_BASE = 'h8000,
  parameter int unsigned EN_BIT = 1,
  parameter int unsigned LK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              irq_ack,
  input  logic              dma_busy,
  input  logic              nmi_level,
  input  logic              wdt_evt,
  input  logic              read_array,
  input  logic              wait_set,
  input  logic              clk_ok,
  output logic              rw_en,
  output logic              lk_rel,
  output logic [7:0]        aux_q,
  output logic              abort_p,
  output logic              seq_err
);

  logic nmi_q, arm_en, arm_lk;

  wire hit_ctl  = bus_we && (bus_addr == CTL_ADDR);
  wire byte_ctl = hit_ctl && !bus_word;
  wire cancel   = irq_ack || dma_busy || !nmi_level;
  wire nmi_evt  = nmi_q && !nmi_level;
  wire force_rst = nmi_evt || wdt_evt;
  wire env_ok   = wait_set && clk_ok;
  wire en_go    = byte_ctl && bus_wdata[EN_BIT] && arm_en && !cancel && !rw_en;
  wire lk_go    = byte_ctl && bus_wdata[LK_BIT] && arm_lk && !cancel;
  wire lk_clr   = byte_ctl && !bus_wdata[LK_BIT];
  wire en_clr   = hit_ctl && bus_word && read_array &&
                  (bus_wdata[15:8] == 8'h00) && !bus_wdata[EN_BIT];
  wire rom_odd  = bus_we && rw_en && (bus_addr >= ROM_BASE) && bus_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q   <= 1'b1;
      arm_en  <= 1'b0;
      arm_lk  <= 1'b0;
      rw_en   <= 1'b0;
      lk_rel  <= 1'b0;
      aux_q   <= 8'h00;
      abort_p <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      nmi_q   <= nmi_level;
      abort_p <= force_rst && rw_en;
      if (force_rst) begin
        arm_en <= 1'b0;
        arm_lk <= 1'b0;
        rw_en  <= 1'b0;
        lk_rel <= 1'b0;
        aux_q  <= 8'h00;
      end else begin
        if (cancel) begin
          arm_en <= 1'b0;
          arm_lk <= 1'b0;
        end else if (bus_we) begin
          arm_en <= byte_ctl && !bus_wdata[EN_BIT];
          arm_lk <= byte_ctl && !bus_wdata[LK_BIT];
        end
        if (en_go && env_ok) rw_en <= 1'b1;
        else if (en_clr)     rw_en <= 1'b0;
        if (lk_go)       lk_rel <= 1'b1;
        else if (lk_clr) lk_rel <= 1'b0;
        if (bus_we && bus_addr == AUX_ADDR) aux_q <= bus_wdata[7:0];
      end
      if ((en_go && !env_ok) || rom_odd) seq_err <= 1'b1;
      else if (en_go && env_ok && !force_rst) seq_err <= 1'b0;
    end
  end

  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_en) |-> $past(bus_we && !bus_word && nmi_level && wait_set && clk_ok));
  // R3
  word_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_word && !rw_en) |=> !rw_en);
  // R7
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rw_en) |-> $past(wdt_evt || !nmi_level || (bus_we && bus_word && read_array)));
  // R8
  force_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_evt |=> (!rw_en && !lk_rel && aux_q == 8'h00));
  // R8
  abort_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (!rw_en && $past(rw_en)));
  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> $past(bus_we));

endmodule

// File: tb/flash_rewrite_guard_bench.sv
`timescale 1ns/1ps
module flash_rewrite_guard_bench;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_word = 0, irq_ack = 0, dma_busy = 0, nmi_level = 1;
  logic wdt_evt = 0, read_array = 0, wait_set = 1, clk_ok = 1;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic rw_en, lk_rel, abort_p, seq_err;
  logic [7:0] aux_q;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  flash_rewrite_guard u_flash_rewrite_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_ack(irq_ack),
    .dma_busy(dma_busy), .nmi_level(nmi_level), .wdt_evt(wdt_evt),
    .read_array(read_array), .wait_set(wait_set), .clk_ok(clk_ok),
    .rw_en(rw_en), .lk_rel(lk_rel), .aux_q(aux_q), .abort_p(abort_p),
    .seq_err(seq_err));

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_rst();
    @(negedge clk);
    rst_n = 0; bus_we = 0; irq_ack = 0; dma_busy = 0; nmi_level = 1;
    wdt_evt = 0; read_array = 0; wait_set = 1; clk_ok = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic w, input logic n);
    bus_we = 1; bus_addr = a; bus_wdata = d; bus_word = w; nmi_level = n;
    @(negedge clk);
    bus_we = 0; nmi_level = 1;
  endtask

  task automatic idle(input logic ia, input logic dm);
    irq_ack = ia; dma_busy = dm;
    @(negedge clk);
    irq_ack = 0; dma_busy = 0;
  endtask

  task automatic enable();
    wr(16'h0057, 16'h0000, 0, 1);
    wr(16'h0057, 16'h0002, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_rst();
    // R1 reset state
    chk(rw_en, 0, "R1 rw_en"); chk(lk_rel, 0, "R1 lk_rel");
    chk(abort_p, 0, "R1 abort_p"); chk(seq_err, 0, "R1 seq_err");
    chk(aux_q, 0, "R1 aux_q");

    // R2 R3 R4 R5 R6 sweep
    for (int c = 0; c < 320; c++) begin
      logic w1, w2, n1, n2, wt, ck, cmp;
      int gap;
      w1 = c[0]; w2 = c[1]; n1 = c[2]; n2 = c[3]; wt = c[4]; ck = c[5]; gap = c / 64;
      do_rst();
      wait_set = wt; clk_ok = ck;
      wr(16'h0057, 16'h0000, w1, n1);
      case (gap)
        1: idle(1, 0);
        2: idle(0, 1);
        3: wr(16'h0100, 16'h0000, 0, 1);
        4: idle(0, 0);
        default: ;
      endcase
      wr(16'h0057, 16'h0002, w2, n2);
      cmp = !w1 && n1 && (gap == 0 || gap == 4) && !w2 && n2;
      chk(rw_en, cmp && wt && ck, "R2 R3 R4 R5 rw_en sweep");
      chk(seq_err, cmp && !(wt && ck), "R6 seq_err sweep");
    end

    // R6 error sticky, cleared by successful enable
    do_rst(); wait_set = 0; enable(); wait_set = 1;
    wr(16'h0100, 16'h0000, 0, 1);
    chk(seq_err, 1, "R6 sticky");
    enable();
    chk(rw_en, 1, "R6 re-enable"); chk(seq_err, 0, "R6 cleared by enable");

    // R7 clear sweep
    for (int c = 0; c < 16; c++) begin
      logic ra, w, hz, eb;
      ra = c[0]; w = c[1]; hz = c[2]; eb = c[3];
      do_rst(); enable();
      read_array = ra;
      wr(16'h0057, {hz ? 8'h00 : 8'h10, eb ? 8'h02 : 8'h00}, w, 1);
      read_array = 0;
      chk(rw_en, !(ra && w && hz && !eb), "R7 clear rule");
    end

    // R8 watchdog and NMI force
    for (int k = 0; k < 2; k++) begin
      do_rst(); enable();
      wr(16'h0055, 16'h00A5, 0, 1);
      wr(16'h0057, 16'h0000, 0, 1); wr(16'h0057, 16'h0004, 0, 1);
      chk(lk_rel, 1, "R11 lk set");
      if (k == 0) begin wdt_evt = 1; @(negedge clk); wdt_evt = 0; end
      else begin nmi_level = 0; @(negedge clk); nmi_level = 1; end
      chk(rw_en, 0, "R8 rw_en forced"); chk(lk_rel, 0, "R8 lk forced");
      chk(aux_q, 0, "R8 aux forced"); chk(abort_p, 1, "R8 abort pulse");
      @(negedge clk);
      chk(abort_p, 0, "R8 abort one cycle");
    end
    // R8 force wins over completing write
    do_rst();
    wr(16'h0057, 16'h0000, 0, 1);
    wdt_evt = 1; wr(16'h0057, 16'h0002, 0, 1); wdt_evt = 0;
    chk(rw_en, 0, "R8 coincident rw_en"); chk(seq_err, 0, "R8 coincident err");
    chk(abort_p, 0, "R8 coincident abort");
    // R8 abort absent when rw_en was 0
    do_rst(); wdt_evt = 1; @(negedge clk); wdt_evt = 0;
    chk(abort_p, 0, "R8 no abort when idle");

    // R9 odd ROM writes
    for (int k = 0; k < 8; k++) begin
      do_rst(); enable();
      wr(16'h8000 + 16'(k * 3), 16'h1234, k[1], 1);
      chk(seq_err, (k * 3) % 2, "R9 odd rom enabled");
    end
    do_rst();
    wr(16'h8001, 16'h1234, 0, 1);
    chk(seq_err, 0, "R9 odd rom disabled");
    do_rst(); enable();
    wr(16'h7FFF, 16'h1234, 0, 1);
    chk(seq_err, 0, "R9 below rom");

    // R10 aux sweep
    do_rst();
    for (int v = 0; v < 256; v++) begin
      wr(16'h0055, 16'(v * 257), v[0], 1);
      chk(aux_q, v, "R10 aux load");
    end

    // R11 lock sequence independent of conditions; clear by byte 0
    do_rst(); wait_set = 0; clk_ok = 0;
    wr(16'h0057, 16'h0000, 0, 1); wr(16'h0057, 16'h0004, 0, 1);
    chk(lk_rel, 1, "R11 lk set without env");
    wr(16'h0057, 16'h0000, 0, 1);
    chk(lk_rel, 0, "R11 lk clear");
    wr(16'h0057, 16'h0000, 0, 1); irq_ack = 1; wr(16'h0057, 16'h0004, 0, 1); irq_ack = 0;
    chk(lk_rel, 0, "R11 R4 lk irq cancel");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule